// File: doc/BRIEF.md
# Command Token Parser for a Multi-Channel Transfer Engine

This block sits in front of a data-transfer engine and turns a stream of 32-bit command tokens into work. Tokens arrive on a valid/ready interface. The first token of each command is a header. The parser reads the command id from the header and uses it to class the command. That class sets how many operand words follow. The parser then counts those words in and routes each one to its target.

Configure commands fill a per-channel register file of eight 32-bit fields. A single-field write command patches one field. Transfer and clear commands produce a descriptor. The descriptor carries the direction, the fill flag, the fast flag, whether an acknowledge is owed, both addresses and the two variable flags. It also carries a snapshot of the addressed channel's configuration.

The descriptor is held on a valid/ready output until the downstream mover takes it. While the descriptor waits, the token input stalls. A run-mode token may come before a transfer and is consumed without effect. Any other unknown id raises a one-cycle error pulse.

Top module: `cmd_token_parser`

## Requirements
- R1: A header token places the command id in bits 5..0, the channel in bits 10..6 and the field index in bits 14..11. The descriptor's channel output equals the channel of the transfer header that produced it.
- R2: A transfer id has bit 5 clear and bit 4 equal to bit 1. Four operand words follow it: destination address, source address or fill value, destination-variable flag (bit 0), then source-variable flag (bit 0). `desc_valid` is high in the cycle after the last operand is accepted, and the outputs carry those words.
- R3: When bit 3 (clear) of a transfer id is set, only three operand words are taken, and `desc_src_var` reads 0.
- R4: `desc_to_b` equals id bit 2 (1 = side A to side B; for a clear, 1 = fill side B, 0 = fill side A). `desc_fast` equals id bit 0.
- R5: `desc_need_ack` is 1 exactly when id bits 4 and 1 are both 0.
- R6: Id 0x20 is followed by eight words. Word k is written to field k of the addressed channel. `desc_cfg` presents field k of the descriptor's channel at bits 32k+31..32k.
- R7: Id 0x21 is followed by one word, which is written only to the field selected by the header's field index. For an index of 8..15 the word is consumed and no field changes.
- R8: Id 0x3F is a run-mode token. It takes no operands and produces neither a descriptor nor an error.
- R9: Any other id sets `cmd_err` high for exactly the one cycle after the header is accepted. The next token is then treated as a header.
- R10: While `desc_valid` is high and `desc_ready` is low, `tok_ready` is low and every descriptor output holds its value.
- R11: After reset, every configuration field is zero, `tok_ready` is 1, and `desc_valid` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token accepted when high with tok_valid |
| tok_data | input | 32 | Header or operand token |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Descriptor taken when high with desc_valid |
| desc_chan | output | 5 | Channel of the descriptor |
| desc_to_b | output | 1 | Direction / fill-side flag |
| desc_clear | output | 1 | Fill (clear) transfer |
| desc_fast | output | 1 | Fast-variant flag |
| desc_need_ack | output | 1 | Acknowledge owed |
| desc_dst | output | 32 | Destination address |
| desc_src | output | 32 | Source address or fill value |
| desc_dst_var | output | 1 | Destination-variable flag |
| desc_src_var | output | 1 | Source-variable flag |
| desc_cfg | output | 256 | The eight configuration fields of the descriptor's channel |
| cmd_err | output | 1 | Unknown-command pulse |

## Verification
The assertions take for granted that `tok_data` is stable and meaningful whenever `tok_valid` is high. They also assume the producer never abandons a command partway, so operand words always arrive in the count the header implies. The stimulus keeps within this. Every command is sent whole through one task that holds each token until it is accepted. Deliberately bad ids are sent only as lone headers, with nothing attached.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    // header field positions (other blocks encode against these)
    localparam int ID_LSB  = 0;
    localparam int ID_W    = 6;
    localparam int CH_LSB  = 6;
    localparam int CH_FW   = 5;
    localparam int IDX_LSB = 11;
    localparam int IDX_W   = 4;

    // command id bit positions
    localparam int B_FAST  = 0;
    localparam int B_CHECK = 1;
    localparam int B_DIR   = 2;
    localparam int B_CLEAR = 3;
    localparam int B_ACK   = 4;
    localparam int B_CFG   = 5;

    localparam logic [ID_W-1:0] ID_CONFIG = 6'h20;
    localparam logic [ID_W-1:0] ID_SETFLD = 6'h21;
    localparam logic [ID_W-1:0] ID_RUN    = 6'h3F;

    localparam int OPS_W = 4;

    typedef enum logic [2:0] {
        CLS_BAD,
        CLS_RUN,
        CLS_CONFIG,
        CLS_SETFLD,
        CLS_XFER
    } cls_e;

    typedef enum logic {
        ST_HDR,
        ST_OPS
    } st_e;

    typedef struct packed {
        cls_e             cls;
        logic [OPS_W-1:0] n_ops;
        logic             fast;
        logic             to_b;
        logic             clear;
        logic             need_ack;
    } hdr_info_t;

endpackage

// File: rtl/ctp_hdr_decode.sv
module ctp_hdr_decode
    import ctp_pkg::*;
#(
    parameter int N_FLD = 8
) (
    input  logic [ID_W-1:0] cmd_id,
    output hdr_info_t       info
);

    always_comb begin
        info = '0;
        info.cls = CLS_BAD;
        if (cmd_id[B_CFG]) begin
            if (cmd_id == ID_CONFIG) begin
                info.cls   = CLS_CONFIG;
                info.n_ops = OPS_W'(N_FLD);
            end else if (cmd_id == ID_SETFLD) begin
                info.cls   = CLS_SETFLD;
                info.n_ops = OPS_W'(1);
            end else if (cmd_id == ID_RUN) begin
                info.cls   = CLS_RUN;
            end
        end else if (cmd_id[B_ACK] == cmd_id[B_CHECK]) begin
            info.cls      = CLS_XFER;
            info.clear    = cmd_id[B_CLEAR];
            info.to_b     = cmd_id[B_DIR];
            info.fast     = cmd_id[B_FAST];
            info.need_ack = !cmd_id[B_ACK] && !cmd_id[B_CHECK];
            info.n_ops    = cmd_id[B_CLEAR] ? OPS_W'(3) : OPS_W'(4);
        end
    end

endmodule

// File: rtl/ctp_cfg_file.sv
module ctp_cfg_file #(
    parameter int N_CH  = 32,
    parameter int N_FLD = 8,
    parameter int W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(N_CH)-1:0]       wr_chan,
    input  logic [$clog2(N_FLD)-1:0]      wr_fld,
    input  logic [W-1:0]                  wr_data,
    input  logic [$clog2(N_CH)-1:0]       rd_chan,
    output logic [N_FLD*W-1:0]            rd_cfg
);

    logic [W-1:0] mem_q [N_CH][N_FLD];
    logic [W-1:0] mem_d [N_CH][N_FLD];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_chan][wr_fld] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) begin
                for (int f = 0; f < N_FLD; f++) begin
                    mem_q[c][f] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar f = 0; f < N_FLD; f++) begin : g_rd
        assign rd_cfg[f*W +: W] = mem_q[rd_chan][f];
    end

    // R6
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_chan)][$past(wr_fld)] == $past(wr_data));

endmodule

// File: rtl/ctp_parser.sv
module ctp_parser
    import ctp_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int N_FLD = 8,
    parameter int W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tok_valid,
    output logic                      tok_ready,
    input  logic [W-1:0]              tok_data,
    input  hdr_info_t                 info,
    input  logic                      desc_ready,
    output logic                      desc_valid,
    output logic [$clog2(N_CH)-1:0]   desc_chan,
    output logic                      desc_to_b,
    output logic                      desc_clear,
    output logic                      desc_fast,
    output logic                      desc_need_ack,
    output logic [W-1:0]              desc_dst,
    output logic [W-1:0]              desc_src,
    output logic                      desc_dst_var,
    output logic                      desc_src_var,
    output logic                      cmd_err,
    output logic                      wr_en,
    output logic [$clog2(N_FLD)-1:0]  wr_fld,
    output logic [W-1:0]              wr_data
);

    localparam int CH_W  = $clog2(N_CH);
    localparam int FLD_W = $clog2(N_FLD);

    typedef struct packed {
        st_e              st;
        cls_e             cls;
        logic [OPS_W-1:0] n_ops;
        logic [OPS_W-1:0] cnt;
        logic [CH_W-1:0]  chan;
        logic [IDX_W-1:0] idx;
        logic             fast;
        logic             to_b;
        logic             clear;
        logic             need_ack;
        logic [W-1:0]     dst;
        logic [W-1:0]     src;
        logic             dvar;
        logic             svar;
        logic             dvalid;
        logic             err;
    } ps_t;

    ps_t  ps_d, ps_q;
    logic fire;

    assign tok_ready = !ps_q.dvalid;
    assign fire      = tok_valid && tok_ready;

    always_comb begin
        ps_d     = ps_q;
        ps_d.err = 1'b0;
        wr_en    = 1'b0;
        wr_fld   = ps_q.cnt[FLD_W-1:0];
        wr_data  = tok_data;

        if (ps_q.dvalid && desc_ready) begin
            ps_d.dvalid = 1'b0;
        end

        if (fire) begin
            if (ps_q.st == ST_HDR) begin
                case (info.cls)
                    CLS_BAD: ps_d.err = 1'b1;
                    CLS_RUN: ;
                    default: begin
                        ps_d.st       = ST_OPS;
                        ps_d.cls      = info.cls;
                        ps_d.n_ops    = info.n_ops;
                        ps_d.cnt      = '0;
                        ps_d.chan     = tok_data[CH_LSB +: CH_W];
                        ps_d.idx      = tok_data[IDX_LSB +: IDX_W];
                        ps_d.fast     = info.fast;
                        ps_d.to_b     = info.to_b;
                        ps_d.clear    = info.clear;
                        ps_d.need_ack = info.need_ack;
                        ps_d.svar     = 1'b0;
                    end
                endcase
            end else begin
                case (ps_q.cls)
                    CLS_CONFIG: wr_en = 1'b1;
                    CLS_SETFLD: begin
                        wr_en  = int'(ps_q.idx) < N_FLD;
                        wr_fld = ps_q.idx[FLD_W-1:0];
                    end
                    default: begin
                        case (ps_q.cnt)
                            OPS_W'(0): ps_d.dst  = tok_data;
                            OPS_W'(1): ps_d.src  = tok_data;
                            OPS_W'(2): ps_d.dvar = tok_data[0];
                            default:   ps_d.svar = tok_data[0];
                        endcase
                    end
                endcase
                ps_d.cnt = ps_q.cnt + OPS_W'(1);
                if (ps_q.cnt == ps_q.n_ops - OPS_W'(1)) begin
                    ps_d.st = ST_HDR;
                    if (ps_q.cls == CLS_XFER) begin
                        ps_d.dvalid = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign desc_valid    = ps_q.dvalid;
    assign desc_chan     = ps_q.chan;
    assign desc_to_b     = ps_q.to_b;
    assign desc_clear    = ps_q.clear;
    assign desc_fast     = ps_q.fast;
    assign desc_need_ack = ps_q.need_ack;
    assign desc_dst      = ps_q.dst;
    assign desc_src      = ps_q.src;
    assign desc_dst_var  = ps_q.dvar;
    assign desc_src_var  = ps_q.svar;
    assign cmd_err       = ps_q.err;

    // R9
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(fire && ps_q.st == ST_HDR));

    // R2
    desc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_valid) |-> $past(fire));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_q.st == ST_OPS |-> ps_q.cnt < ps_q.n_ops);

    // R3
    clear_srcvar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_clear |-> !desc_src_var);

endmodule

// File: rtl/cmd_token_parser.sv
module cmd_token_parser
    import ctp_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int N_FLD = 8,   // at most 15: operand counter is OPS_W bits
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tok_valid,
    output logic                         tok_ready,
    input  logic [W-1:0]                 tok_data,
    output logic                         desc_valid,
    input  logic                         desc_ready,
    output logic [$clog2(N_CH)-1:0]      desc_chan,
    output logic                         desc_to_b,
    output logic                         desc_clear,
    output logic                         desc_fast,
    output logic                         desc_need_ack,
    output logic [W-1:0]                 desc_dst,
    output logic [W-1:0]                 desc_src,
    output logic                         desc_dst_var,
    output logic                         desc_src_var,
    output logic [N_FLD*W-1:0]           desc_cfg,
    output logic                         cmd_err
);

    localparam int FLD_W = $clog2(N_FLD);

    hdr_info_t          info;
    logic               wr_en;
    logic [FLD_W-1:0]   wr_fld;
    logic [W-1:0]       wr_data;

    ctp_hdr_decode #(.N_FLD(N_FLD)) u_dec (
        .cmd_id (tok_data[ID_LSB +: ID_W]),
        .info   (info)
    );

    ctp_parser #(.N_CH(N_CH), .N_FLD(N_FLD), .W(W)) u_prs (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .tok_ready     (tok_ready),
        .tok_data      (tok_data),
        .info          (info),
        .desc_ready    (desc_ready),
        .desc_valid    (desc_valid),
        .desc_chan     (desc_chan),
        .desc_to_b     (desc_to_b),
        .desc_clear    (desc_clear),
        .desc_fast     (desc_fast),
        .desc_need_ack (desc_need_ack),
        .desc_dst      (desc_dst),
        .desc_src      (desc_src),
        .desc_dst_var  (desc_dst_var),
        .desc_src_var  (desc_src_var),
        .cmd_err       (cmd_err),
        .wr_en         (wr_en),
        .wr_fld        (wr_fld),
        .wr_data       (wr_data)
    );

    // the write channel and the descriptor channel share one register
    ctp_cfg_file #(.N_CH(N_CH), .N_FLD(N_FLD), .W(W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_chan (desc_chan),
        .wr_fld  (wr_fld),
        .wr_data (wr_data),
        .rd_chan (desc_chan),
        .rd_cfg  (desc_cfg)
    );

    // R10
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && !tok_ready
            && $stable(desc_dst) && $stable(desc_src) && $stable(desc_cfg)
            && $stable(desc_chan));

endmodule

// File: tb/cmd_token_parser_tb.sv
`timescale 1ns/1ps
module cmd_token_parser_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tok_valid = 1'b0;
    logic         tok_ready;
    logic [31:0]  tok_data = '0;
    logic         desc_valid;
    logic         desc_ready = 1'b0;
    logic [4:0]   desc_chan;
    logic         desc_to_b, desc_clear, desc_fast, desc_need_ack;
    logic [31:0]  desc_dst, desc_src;
    logic         desc_dst_var, desc_src_var;
    logic [255:0] desc_cfg;
    logic         cmd_err;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_cfg [32][8];

    always #10 clk = ~clk;

    cmd_token_parser u_dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_data(tok_data), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_chan(desc_chan), .desc_to_b(desc_to_b), .desc_clear(desc_clear),
        .desc_fast(desc_fast), .desc_need_ack(desc_need_ack), .desc_dst(desc_dst),
        .desc_src(desc_src), .desc_dst_var(desc_dst_var), .desc_src_var(desc_src_var),
        .desc_cfg(desc_cfg), .cmd_err(cmd_err)
    );

    typedef struct packed {
        logic [5:0]  id;
        logic [4:0]  ch;
        logic [31:0] dst;
        logic [31:0] src;
        logic        dv;
        logic        sv;
        logic        pre_run;
        logic        e_tob;
        logic        e_clr;
        logic        e_ack;
        logic        e_fast;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 5'd3,  32'h0000_1000, 32'h8000_0040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{6'h04, 5'd7,  32'h0000_2220, 32'h9000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{6'h16, 5'd31, 32'hCAFE_0000, 32'h0000_BEEF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{6'h08, 5'd0,  32'h0000_0100, 32'h5A5A_5A5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{6'h1E, 5'd12, 32'h0000_0200, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{6'h05, 5'd20, 32'h1234_0000, 32'h0000_4321, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{6'h13, 5'd9,  32'h0BAD_F00D, 32'h7777_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    function automatic logic [31:0] hdr(input logic [5:0] id, input logic [4:0] ch,
                                        input logic [3:0] idx);
        return {17'd0, idx, ch, id};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_data  = w;
        while (!tok_ready) @(negedge clk);
        @(posedge clk);
        #1;
        tok_valid = 1'b0;
    endtask

    task automatic take_desc();
        @(negedge clk);
        desc_ready = 1'b1;
        @(posedge clk);
        #1;
        desc_ready = 1'b0;
    endtask

    task automatic send_xfer(input logic [5:0] id, input logic [4:0] ch,
                             input logic [31:0] dst, input logic [31:0] src,
                             input logic dv, input logic sv);
        send(hdr(id, ch, 4'd0));
        send(dst);
        send(src);
        send({31'd0, dv});
        if (!id[3]) send({31'd0, sv});
    endtask

    task automatic chk_cfg(input string req, input int ch);
        for (int f = 0; f < 8; f++) begin
            chk(req, 64'(desc_cfg[f*32 +: 32]), 64'(exp_cfg[ch][f]));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 32; c++)
            for (int f = 0; f < 8; f++) exp_cfg[c][f] = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", 64'(tok_ready), 64'd1);
        chk("R11 desc_valid", 64'(desc_valid), 64'd0);
        chk("R11 err", 64'(cmd_err), 64'd0);

        // table walk: transfer and clear variants (R1..R5, R8, R10, R11)
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].pre_run) send(hdr(6'h3F, 5'd0, 4'd0));
            send_xfer(VECS[i].id, VECS[i].ch, VECS[i].dst, VECS[i].src,
                      VECS[i].dv, VECS[i].sv);
            @(negedge clk);
            chk("R2 valid", 64'(desc_valid), 64'd1);
            chk("R1 chan", 64'(desc_chan), 64'(VECS[i].ch));
            chk("R4 to_b", 64'(desc_to_b), 64'(VECS[i].e_tob));
            chk("R4 fast", 64'(desc_fast), 64'(VECS[i].e_fast));
            chk("R3 clear", 64'(desc_clear), 64'(VECS[i].e_clr));
            chk("R5 ack", 64'(desc_need_ack), 64'(VECS[i].e_ack));
            chk("R2 dst", 64'(desc_dst), 64'(VECS[i].dst));
            chk("R2 src", 64'(desc_src), 64'(VECS[i].src));
            chk("R2 dst_var", 64'(desc_dst_var), 64'(VECS[i].dv));
            chk("R3 src_var", 64'(desc_src_var),
                64'(VECS[i].e_clr ? 1'b0 : VECS[i].sv));
            chk("R8 no err", 64'(cmd_err), 64'd0);
            if (i == 0) chk_cfg("R11 cfg zero", 3);
            repeat (2) @(negedge clk);
            chk("R10 ready low", 64'(tok_ready), 64'd0);
            chk("R10 held", 64'(desc_dst), 64'(VECS[i].dst));
            take_desc();
            @(negedge clk);
            chk("R10 released", 64'(desc_valid), 64'd0);
        end

        // R6 full configure of channel 5
        send(hdr(6'h20, 5'd5, 4'd0));
        for (int f = 0; f < 8; f++) begin
            exp_cfg[5][f] = 32'hA000_0000 + 32'(f * 32'h0101);
            send(exp_cfg[5][f]);
        end
        @(negedge clk);
        chk("R6 no desc", 64'(desc_valid), 64'd0);
        send_xfer(6'h04, 5'd5, 32'h10, 32'h20, 1'b0, 1'b0);
        @(negedge clk);
        chk_cfg("R6 cfg", 5);
        take_desc();

        // R7 single field write, index 3
        send(hdr(6'h21, 5'd5, 4'd3));
        send(32'hDEAD_BEEF);
        exp_cfg[5][3] = 32'hDEAD_BEEF;
        send_xfer(6'h04, 5'd5, 32'h10, 32'h20, 1'b0, 1'b0);
        @(negedge clk);
        chk_cfg("R7 one field", 5);
        take_desc();

        // R7 out-of-range index consumes its word, changes nothing
        send(hdr(6'h21, 5'd5, 4'd12));
        send(32'h1234_5678);
        send_xfer(6'h00, 5'd5, 32'h30, 32'h40, 1'b1, 1'b0);
        @(negedge clk);
        chk("R7 next header ok", 64'(desc_dst), 64'h30);
        chk_cfg("R7 idx range", 5);
        take_desc();

        // R9 unknown ids: configure-class and transfer-class
        send(hdr(6'h30, 5'd1, 4'd0));
        chk("R9 err pulse", 64'(cmd_err), 64'd1);
        @(posedge clk);
        #1;
        chk("R9 err one cycle", 64'(cmd_err), 64'd0);
        send(hdr(6'h02, 5'd1, 4'd0));
        chk("R9 err pulse xfer", 64'(cmd_err), 64'd1);
        send_xfer(6'h04, 5'd2, 32'h55, 32'h66, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9 back to header", 64'(desc_chan), 64'd2);
        chk("R9 src", 64'(desc_src), 64'h66);
        take_desc();

        // R8 lone run-mode token
        send(hdr(6'h3F, 5'd4, 4'd0));
        @(negedge clk);
        chk("R8 no desc", 64'(desc_valid), 64'd0);
        chk("R8 no err", 64'(cmd_err), 64'd0);

        // R11 reset clears configuration
        do_reset();
        send_xfer(6'h04, 5'd5, 32'h1, 32'h2, 1'b0, 1'b0);
        @(negedge clk);
        chk_cfg("R11 cfg cleared", 5);
        take_desc();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule